// File: doc/BRIEF.md
# Duplicated Event Counter Monitor

This block watches the event stream of a register file and keeps running counts of reads, writes, corrected-error reads and uncorrected-error reads. There is one set of four counters for each register and one set of four totals. The whole counter store and its increment logic exist twice. Both copies take the same event inputs and update in the same cycle, so software that reads both copies over the bus can detect an upset in either one by comparing them. No voting between the copies happens inside the block.

Each event cycle carries a read strobe, a write strobe, a register index and a two-bit result status. The status counts only on a read: 01 means a single flipped bit was corrected, and 10 means an uncorrectable two-bit flip was found. Counters wrap to zero when they overflow. Bus access and event traffic never happen at the same time.

The bus side is a read-only slave driven by a two-state handshake machine. In BUS_IDLE, a valid request captures the addressed word and takes the IDLE-to-ACK transition. BUS_ACK raises ready for exactly one cycle and then takes the ACK-to-IDLE transition without any condition. Writes and undefined addresses take the same path, so they acknowledge in the same way but change nothing.

Top module: `evmon_dual_counters`

## Requirements
- R1: After reset, every counter in both copies reads as zero and ready is low.
- R2: A cycle with the read strobe high adds one to the read counter of the indexed register, at copy offset idx*16+0, and to the read total at offset 0x1000.
- R3: A cycle with the write strobe high adds one to the write counter of the indexed register, at offset idx*16+4, and to the write total at offset 0x1004.
- R4: On a read cycle, status 01 adds one to the corrected counter (idx*16+8) and to its total (0x1008). Status 10 adds one to the uncorrected counter (idx*16+12) and to its total (0x100C). Statuses 00 and 11 touch neither.
- R5: The status input is ignored when the read strobe is low, so neither error counter moves.
- R6: The second copy sits 0x1_0000 above the first with the same layout, and it holds the same values as the first copy in every cycle after reset.
- R7: A counter at its all-ones value wraps to zero on its next increment.
- R8: A request seen in BUS_IDLE is acknowledged in the next cycle, with the read data valid in that same cycle, and ready stays high for exactly one cycle.
- R9: A read of an undefined address is acknowledged and returns zero. Undefined addresses are: any address with a nonzero bit above bit 16, a low two-bit value other than 00, an offset at or past NUM_REGS*16 below 0x1000, or any other offset outside 0x1000 to 0x100C.
- R10: A bus write is acknowledged and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; clears all counters |
| rd_evt_i | input | 1 | Register-file read event |
| wr_evt_i | input | 1 | Register-file write event |
| evt_idx_i | input | IDX_W | Index of the register addressed by the event |
| evt_status_i | input | 2 | Result status of the read (00 clean, 01 corrected, 10 uncorrectable) |
| bus_valid_i | input | 1 | Bus request valid |
| bus_we_i | input | 1 | Bus request is a write |
| bus_adr_i | input | ADDR_W | Byte address; bit 16 selects the copy |
| bus_ready_o | output | 1 | One-cycle acknowledge |
| bus_rdata_o | output | DATA_W | Read data, valid while ready is high |

## Verification
The bench builds the block with NUM_REGS = 32 and CNT_W = 8. Keeping the full register count exercises the complete address layout and its upper boundary at offset 0x200. The narrow counter width brings the wrap from 255 to zero within a few hundred events. A vector table of mixed read, write and status events is followed by a full readback of both copies, which is compared against a model kept in the bench. Directed tests then cover undefined addresses, bus writes, status without a read, and the wrap.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
    localparam int NUM_COPIES = 2;
    localparam int NUM_KINDS  = 4;

    // Order fixes the word position of each counter inside a register's set.
    typedef enum logic [1:0] {
        EV_READ   = 2'd0,
        EV_WRITE  = 2'd1,
        EV_CORR   = 2'd2,
        EV_UNCORR = 2'd3
    } ev_kind_e;

    localparam logic [1:0] ST_CLEAN  = 2'b00;
    localparam logic [1:0] ST_CORR   = 2'b01;
    localparam logic [1:0] ST_UNCORR = 2'b10;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;
endpackage

// File: rtl/evmon_copy.sv
module evmon_copy
    import evmon_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int CNT_W    = 32,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                                          clk_i,
    input  logic                                          rst_i,
    input  logic                                          rd_i,
    input  logic                                          wr_i,
    input  logic [IDX_W-1:0]                              idx_i,
    input  logic [1:0]                                    status_i,
    output logic [NUM_REGS-1:0][NUM_KINDS-1:0][CNT_W-1:0] per_o,
    output logic [NUM_KINDS-1:0][CNT_W-1:0]               tot_o
);
    logic [NUM_KINDS-1:0] ev_hit;

    always_comb begin
        ev_hit            = '0;
        ev_hit[EV_READ]   = rd_i;
        ev_hit[EV_WRITE]  = wr_i;
        ev_hit[EV_CORR]   = rd_i && (status_i == ST_CORR);
        ev_hit[EV_UNCORR] = rd_i && (status_i == ST_UNCORR);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            per_o <= '0;
            tot_o <= '0;
        end else begin
            for (int k = 0; k < NUM_KINDS; k++) begin
                if (ev_hit[k]) begin
                    tot_o[k]        <= tot_o[k] + CNT_W'(1);
                    per_o[idx_i][k] <= per_o[idx_i][k] + CNT_W'(1);
                end
            end
        end
    end

    // R5: error totals hold whenever no read is presented
    p_err_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_i |=> ($stable(tot_o[EV_CORR]) && $stable(tot_o[EV_UNCORR])));

    // R7: an all-ones read total returns to zero on the next read
    p_wrap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && (tot_o[EV_READ] == {CNT_W{1'b1}})) |=> (tot_o[EV_READ] == '0));
endmodule

// File: rtl/evmon_bus_fsm.sv
module evmon_bus_fsm
    import evmon_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int CNT_W    = 32,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                                                          clk_i,
    input  logic                                                          rst_i,
    input  logic                                                          valid_i,
    input  logic                                                          we_i,
    input  logic [ADDR_W-1:0]                                             adr_i,
    input  logic [NUM_COPIES-1:0][NUM_REGS-1:0][NUM_KINDS-1:0][CNT_W-1:0] per_i,
    input  logic [NUM_COPIES-1:0][NUM_KINDS-1:0][CNT_W-1:0]               tot_i,
    output logic                                                          ready_o,
    output logic [DATA_W-1:0]                                             rdata_o
);
    localparam logic [16:0] PER_LIMIT = 17'(NUM_REGS * 16);
    localparam logic [11:0] TOT_PAGE  = 12'h100;

    bus_state_e         state_q, state_d;
    logic [15:0]        off;
    logic               copy_sel, legal, per_hit, tot_hit;
    logic [IDX_W-1:0]   reg_sel;
    logic [1:0]         kind_sel;
    logic [DATA_W-1:0]  rd_word;

    always_comb begin
        off      = adr_i[15:0];
        copy_sel = adr_i[16];
        legal    = (adr_i[ADDR_W-1:17] == '0) && (adr_i[1:0] == 2'b00) && !we_i;
        per_hit  = legal && ({1'b0, off} < PER_LIMIT);
        tot_hit  = legal && (off[15:4] == TOT_PAGE);
        reg_sel  = off[IDX_W+3:4];
        kind_sel = off[3:2];
        rd_word  = '0;
        if (per_hit)
            rd_word = DATA_W'(per_i[copy_sel][reg_sel][kind_sel]);
        else if (tot_hit)
            rd_word = DATA_W'(tot_i[copy_sel][kind_sel]);
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= BUS_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (valid_i) state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
        endcase
    end

    // Outputs: data captured on the IDLE-to-ACK transition
    always_ff @(posedge clk_i) begin
        if (rst_i)
            rdata_o <= '0;
        else if (state_q == BUS_IDLE && valid_i)
            rdata_o <= rd_word;
    end

    assign ready_o = (state_q == BUS_ACK);

    // R8: acknowledge follows a request seen in idle
    p_ack_next_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == BUS_IDLE && valid_i) |=> ready_o);

    // R8: acknowledge lasts one cycle
    p_ack_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |=> !ready_o);
endmodule

// File: rtl/evmon_dual_counters.sv
module evmon_dual_counters
    import evmon_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int CNT_W    = 32,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rd_evt_i,
    input  logic              wr_evt_i,
    input  logic [IDX_W-1:0]  evt_idx_i,
    input  logic [1:0]        evt_status_i,
    input  logic              bus_valid_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_adr_i,
    output logic              bus_ready_o,
    output logic [DATA_W-1:0] bus_rdata_o
);
    logic [NUM_COPIES-1:0][NUM_REGS-1:0][NUM_KINDS-1:0][CNT_W-1:0] per_all;
    logic [NUM_COPIES-1:0][NUM_KINDS-1:0][CNT_W-1:0]               tot_all;

    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
        evmon_copy #(
            .NUM_REGS (NUM_REGS),
            .CNT_W    (CNT_W)
        ) u_copy (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .rd_i     (rd_evt_i),
            .wr_i     (wr_evt_i),
            .idx_i    (evt_idx_i),
            .status_i (evt_status_i),
            .per_o    (per_all[c]),
            .tot_o    (tot_all[c])
        );
    end

    evmon_bus_fsm #(
        .NUM_REGS (NUM_REGS),
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_bus (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .valid_i  (bus_valid_i),
        .we_i     (bus_we_i),
        .adr_i    (bus_adr_i),
        .per_i    (per_all),
        .tot_i    (tot_all),
        .ready_o  (bus_ready_o),
        .rdata_o  (bus_rdata_o)
    );

    // R6: the two independent copies agree in every cycle
    p_copies_agree_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (per_all[0] == per_all[1]) && (tot_all[0] == tot_all[1]));
endmodule

// File: tb/evmon_dual_counters_bench.sv
`timescale 1ns/1ps
module evmon_dual_counters_bench;
    localparam int NUM_REGS = 32;
    localparam int CNT_W    = 8;
    localparam int MASK     = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_evt = 1'b0, wr_evt = 1'b0;
    logic [4:0]  idx = '0;
    logic [1:0]  st = '0;
    logic        valid = 1'b0, we = 1'b0;
    logic [31:0] adr = '0;
    logic        ready;
    logic [31:0] rdata;

    int n_chk = 0, n_fail = 0;
    int m_per [NUM_REGS][4];
    int m_tot [4];

    always #10 clk = ~clk;

    evmon_dual_counters #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_evmon_dual_counters (
        .clk_i(clk), .rst_i(rst), .rd_evt_i(rd_evt), .wr_evt_i(wr_evt),
        .evt_idx_i(idx), .evt_status_i(st), .bus_valid_i(valid), .bus_we_i(we),
        .bus_adr_i(adr), .bus_ready_o(ready), .bus_rdata_o(rdata));

    // {rd, wr, idx[4:0], status[1:0]}
    localparam logic [8:0] VEC [14] = '{
        {1'b1, 1'b0, 5'd0,  2'b00}, {1'b0, 1'b1, 5'd0,  2'b00},
        {1'b1, 1'b0, 5'd3,  2'b01}, {1'b1, 1'b0, 5'd3,  2'b10},
        {1'b0, 1'b1, 5'd31, 2'b01}, {1'b1, 1'b0, 5'd31, 2'b11},
        {1'b1, 1'b1, 5'd7,  2'b01}, {1'b0, 1'b1, 5'd7,  2'b10},
        {1'b1, 1'b0, 5'd16, 2'b10}, {1'b1, 1'b0, 5'd16, 2'b10},
        {1'b0, 1'b0, 5'd9,  2'b01}, {1'b1, 1'b0, 5'd0,  2'b01},
        {1'b0, 1'b1, 5'd15, 2'b00}, {1'b1, 1'b0, 5'd1,  2'b00}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ev(input logic r, input logic w, input logic [4:0] i, input logic [1:0] s);
        @(negedge clk);
        rd_evt = r; wr_evt = w; idx = i; st = s;
        @(negedge clk);
        rd_evt = 1'b0; wr_evt = 1'b0; st = 2'b00;
        if (r) begin
            m_per[i][0] = (m_per[i][0] + 1) & MASK; m_tot[0] = (m_tot[0] + 1) & MASK;
            if (s == 2'b01) begin m_per[i][2] = (m_per[i][2] + 1) & MASK; m_tot[2] = (m_tot[2] + 1) & MASK; end
            if (s == 2'b10) begin m_per[i][3] = (m_per[i][3] + 1) & MASK; m_tot[3] = (m_tot[3] + 1) & MASK; end
        end
        if (w) begin
            m_per[i][1] = (m_per[i][1] + 1) & MASK; m_tot[1] = (m_tot[1] + 1) & MASK;
        end
    endtask

    task automatic bus_op(input logic wr, input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; we = wr; adr = a;
        @(negedge clk);
        chk("R8", "ready in cycle after request", 32'(ready), 32'd1);
        d = rdata;
        valid = 1'b0; we = 1'b0;
        @(negedge clk);
        chk("R8", "ready dropped after one cycle", 32'(ready), 32'd0);
    endtask

    function automatic logic [31:0] per_adr(input int c, input int r, input int k);
        return 32'(c * 32'h1_0000 + r * 16 + k * 4);
    endfunction

    function automatic logic [31:0] tot_adr(input int c, input int k);
        return 32'(c * 32'h1_0000 + 32'h1000 + k * 4);
    endfunction

    task automatic readback_all();
        logic [31:0] d;
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                for (int k = 0; k < 4; k++) begin
                    bus_op(1'b0, per_adr(c, r, k), d);
                    if (c == 1) chk("R6", "second copy per-register counter", d, 32'(m_per[r][k]));
                    else if (k == 0) chk("R2", "read counter", d, 32'(m_per[r][k]));
                    else if (k == 1) chk("R3", "write counter", d, 32'(m_per[r][k]));
                    else chk("R4", "error counter", d, 32'(m_per[r][k]));
                end
            end
            for (int k = 0; k < 4; k++) begin
                bus_op(1'b0, tot_adr(c, k), d);
                chk(c == 1 ? "R6" : (k == 0 ? "R2" : (k == 1 ? "R3" : "R4")), "total counter", d, 32'(m_tot[k]));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int r = 0; r < NUM_REGS; r++) for (int k = 0; k < 4; k++) m_per[r][k] = 0;
        for (int k = 0; k < 4; k++) m_tot[k] = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "ready after reset", 32'(ready), 32'd0);
        bus_op(1'b0, per_adr(0, 0, 0), d);  chk("R1", "copy0 reg0 reads", d, 32'd0);
        bus_op(1'b0, per_adr(1, 31, 3), d); chk("R1", "copy1 reg31 uncorrected", d, 32'd0);
        bus_op(1'b0, tot_adr(1, 1), d);     chk("R1", "copy1 total writes", d, 32'd0);

        // Vector table walk, then full readback of both copies (R2, R3, R4, R6)
        for (int v = 0; v < 14; v++) ev(VEC[v][8], VEC[v][7], VEC[v][6:2], VEC[v][1:0]);
        readback_all();

        // R5: status without read moves no error counter
        ev(1'b0, 1'b1, 5'd12, 2'b01);
        ev(1'b0, 1'b0, 5'd12, 2'b10);
        bus_op(1'b0, per_adr(0, 12, 2), d); chk("R5", "corrected without read", d, 32'd0);
        bus_op(1'b0, per_adr(0, 12, 3), d); chk("R5", "uncorrected without read", d, 32'd0);
        bus_op(1'b0, tot_adr(0, 2), d);     chk("R5", "corrected total", d, 32'(m_tot[2]));
        bus_op(1'b0, tot_adr(1, 3), d);     chk("R5", "uncorrected total copy1", d, 32'(m_tot[3]));

        // R9: undefined addresses return zero with acknowledge
        bus_op(1'b0, 32'h0000_0200, d); chk("R9", "just past per-register area", d, 32'd0);
        bus_op(1'b0, 32'h0000_1010, d); chk("R9", "just past totals", d, 32'd0);
        bus_op(1'b0, 32'h0000_0800, d); chk("R9", "gap below totals", d, 32'd0);
        bus_op(1'b0, 32'h0000_0001, d); chk("R9", "unaligned", d, 32'd0);
        bus_op(1'b0, 32'h0004_0000, d); chk("R9", "upper address bit", d, 32'd0);
        bus_op(1'b0, 32'h0001_2000, d); chk("R9", "copy1 unmapped page", d, 32'd0);

        // R10: bus writes change nothing
        bus_op(1'b1, per_adr(0, 3, 0), d);
        bus_op(1'b1, tot_adr(1, 0), d);
        bus_op(1'b0, per_adr(0, 3, 0), d); chk("R10", "reg3 reads after write", d, 32'(m_per[3][0]));
        bus_op(1'b0, tot_adr(1, 0), d);    chk("R10", "copy1 total reads after write", d, 32'(m_tot[0]));

        // R7: wrap of reg 7 read counter
        while (m_per[7][0] != MASK) ev(1'b1, 1'b0, 5'd7, 2'b00);
        bus_op(1'b0, per_adr(0, 7, 0), d); chk("R7", "counter at all ones", d, 32'(MASK));
        ev(1'b1, 1'b0, 5'd7, 2'b00);
        bus_op(1'b0, per_adr(0, 7, 0), d); chk("R7", "counter wrapped", d, 32'd0);
        bus_op(1'b0, per_adr(1, 7, 0), d); chk("R7", "copy1 counter wrapped", d, 32'd0);
        bus_op(1'b0, tot_adr(0, 0), d);    chk("R7", "read total modulo", d, 32'(m_tot[0]));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule